// File: doc/BRIEF.md
# I2C Memory Transaction Sequencer

This block turns one request (write, read, or presence probe) into the full series of byte-level commands that an I2C master engine executes. Each command is START, STOP, WRITE of one byte, or READ of one byte. The engine returns exactly one response per command. That response carries the acknowledge seen on a written byte, or the byte that was read.

The sequencer formats the device byte, which can include high memory-address bits folded into the device address. It then sends the memory address bytes and turns the bus around for reads. Received bytes go out on a valid/ready stream and bytes to write come in on another. At the end it pulses `done_o` with a status code and a count of data bytes the target refused.

A typical use is serial EEPROM access. It also covers write-completion polling, by probing repeatedly until the device acknowledges its address.

Top module: `i2c_mem_seq`

## Requirements
- R1: The device byte holds the 7-bit effective device address in bits 7:1. Bit 0 is 0 in a write phase and 1 in a read phase.
- R2: For write and read requests, exactly `req_alen_i` memory address bytes follow the write-phase device byte, most significant byte first.
- R3: With `cfg_ovf_en_i` set, the effective device address is the requested address ORed with `((mem_addr >> 8*alen) & cfg_ovf_mask_i)`. That term is 0 when alen equals the address width in bytes. With the bit clear, the requested address is used unchanged.
- R4: A read with alen 0 has no write phase: START, then the read-direction device byte, then the data reads.
- R5: A read with alen > 0 turns from write phase to read phase with STOP then START by default. With `cfg_rep_start_i` set it uses START alone.
- R6: A read of N bytes issues N READ commands. `cmd_nack_o` is 1 only on the last of them, and STOP follows it. The bytes leave on `rd_data_o` in arrival order, each held until `rd_ready_i`.
- R7: A NACK on the write-phase device byte leads to STOP only, and the request ends with status 1 (no device).
- R8: A NACK on any memory address byte leads to STOP only, and the request ends with status 2 (address refused).
- R9: In a write, a NACKed data byte increments `fail_cnt_o` and the transfer goes on. STOP follows the last byte, and the status is 0.
- R10: A probe is START, the write-direction device byte, then STOP. The status is 0 if the byte was acknowledged and 1 if it was not.
- R11: A transfer length of 0 still performs the address phase (and the read-direction device byte for reads), then STOP.
- R12: Command codes on `cmd_op_o` are START=0, STOP=1, WRITE=2, READ=3. `cmd_data_o` is 0 except for WRITE. A command stays stable until `cmd_ready_i` accepts it.
- R13: After reset `req_ready_o` is 1 and `cmd_valid_o`, `rd_valid_o` and `done_o` are 0. One cycle after `done_o`, `req_ready_o` is 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Sequencer idle and able to take a request |
| req_op_i | input | 2 | 0 write, 1 read, 2 probe |
| req_dev_i | input | 7 | Device address |
| req_mem_addr_i | input | 8*ADDR_BYTES | Memory address |
| req_alen_i | input | ALEN_W | Memory address bytes, 0 to ADDR_BYTES |
| req_len_i | input | LEN_W | Data bytes to transfer |
| cfg_rep_start_i | input | 1 | Read turnaround with bare repeated START |
| cfg_ovf_en_i | input | 1 | Fold overflow address bits into the device address |
| cfg_ovf_mask_i | input | 7 | Mask for the folded bits |
| wr_data_i | input | 8 | Byte to write |
| wr_valid_i | input | 1 | Write byte valid |
| wr_ready_o | output | 1 | Write byte taken |
| rd_data_o | output | 8 | Byte read |
| rd_valid_o | output | 1 | Read byte valid |
| rd_ready_i | input | 1 | Read byte taken |
| cmd_valid_o | output | 1 | Engine command valid |
| cmd_ready_i | input | 1 | Engine accepts the command |
| cmd_op_o | output | 2 | Engine command code |
| cmd_data_o | output | 8 | Byte for WRITE |
| cmd_nack_o | output | 1 | Reply NACK after this READ |
| rsp_valid_i | input | 1 | Engine finished the outstanding command |
| rsp_nack_i | input | 1 | Written byte was not acknowledged |
| rsp_data_i | input | 8 | Byte returned by READ |
| done_o | output | 1 | One-cycle end-of-request pulse |
| status_o | output | 2 | 0 ok, 1 no device, 2 address refused |
| fail_cnt_o | output | LEN_W | NACKed data bytes in the last write |

## Verification
A wrong phase state shows up in the command stream at once: the very next accepted command carries an unexpected code, byte, or NACK flag. For this reason every accepted command is compared in order against a queue built from the requirements. A bad byte index or length count either corrupts the next address or data byte, or moves the STOP one command early or late. Errors in the status or failure counter appear only at the `done_o` pulse that ends the request. That pulse is checked against an expected status and count for each request.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  typedef enum logic [1:0] {OP_WRITE = 2'd0, OP_READ = 2'd1, OP_PROBE = 2'd2} req_op_e;
  typedef enum logic [1:0] {CMD_START = 2'd0, CMD_STOP = 2'd1, CMD_WRITE = 2'd2, CMD_READ = 2'd3} cmd_op_e;
  typedef enum logic [1:0] {ST_OK = 2'd0, ST_NODEV = 2'd1, ST_ADDR = 2'd2} status_e;
  typedef enum logic [3:0] {
    PH_IDLE, PH_START, PH_DEVW, PH_ADDR, PH_TSTOP, PH_TSTART,
    PH_DEVR, PH_WDATA, PH_RDATA, PH_RDOUT, PH_STOP, PH_DONE
  } phase_e;
endpackage

// File: rtl/i2c_seq_addr_fmt.sv
module i2c_seq_addr_fmt #(
  parameter int ADDR_BYTES = 4,
  parameter int ALEN_W     = $clog2(ADDR_BYTES + 1)
) (
  input  logic [6:0]              dev_i,
  input  logic [8*ADDR_BYTES-1:0] mem_addr_i,
  input  logic [ALEN_W-1:0]       alen_i,
  input  logic [ALEN_W-1:0]       idx_i,
  input  logic                    ovf_en_i,
  input  logic [6:0]              ovf_mask_i,
  output logic [6:0]              dev_eff_o,
  output logic [7:0]              addr_byte_o
);
  logic [7:0]        byte_arr [ADDR_BYTES];
  logic [6:0]        ovf_arr  [ADDR_BYTES+1];
  logic [ALEN_W-1:0] sel;
  logic [6:0]        ovf_sel;

  for (genvar i = 0; i < ADDR_BYTES; i++) begin : g_bytes
    assign byte_arr[i] = mem_addr_i[8*i +: 8];
    assign ovf_arr[i]  = mem_addr_i[8*i +: 7];
  end
  assign ovf_arr[ADDR_BYTES] = '0;

  // most significant byte goes first
  assign sel = alen_i - idx_i - ALEN_W'(1);

  always_comb begin
    addr_byte_o = '0;
    for (int i = 0; i < ADDR_BYTES; i++)
      if (sel == ALEN_W'(i)) addr_byte_o = byte_arr[i];
  end

  always_comb begin
    ovf_sel = '0;
    for (int a = 0; a <= ADDR_BYTES; a++)
      if (alen_i == ALEN_W'(a)) ovf_sel = ovf_arr[a];
  end

  assign dev_eff_o = dev_i | (ovf_en_i ? (ovf_sel & ovf_mask_i) : 7'd0);
endmodule

// File: rtl/i2c_seq_len_ctr.sv
module i2c_seq_len_ctr #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] len_i,
  input  logic         dec_i,
  output logic         zero_o,
  output logic         last_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= len_i;
    else if (dec_i)  cnt_q <= cnt_q - W'(1);
  end

  assign zero_o = (cnt_q == '0);
  assign last_o = (cnt_q == W'(1));

  a_r6_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> cnt_q != '0);
endmodule

// File: rtl/i2c_seq_fail_ctr.sv
module i2c_seq_fail_ctr #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [W-1:0] bound_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q, bound_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      bound_q <= '0;
    end else if (clr_i) begin
      cnt_q   <= '0;
      bound_q <= bound_i;
    end else if (inc_i) begin
      cnt_q <= cnt_q + W'(1);
    end
  end

  assign cnt_o = cnt_q;

  a_r9_fail_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= bound_q);
endmodule

// File: rtl/i2c_seq_fsm.sv
module i2c_seq_fsm
  import i2c_seq_pkg::*;
#(
  parameter int ALEN_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  output logic              accept_o,
  input  logic [1:0]        op_i,
  input  logic [ALEN_W-1:0] alen_i,
  input  logic              rep_i,
  input  logic [6:0]        dev_i,
  input  logic [7:0]        addr_byte_i,
  output logic [ALEN_W-1:0] idx_o,
  input  logic              zero_i,
  input  logic              last_i,
  output logic              len_dec_o,
  output logic              fail_inc_o,
  input  logic [7:0]        wr_data_i,
  input  logic              wr_valid_i,
  output logic              wr_ready_o,
  output logic [7:0]        rd_data_o,
  output logic              rd_valid_o,
  input  logic              rd_ready_i,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [1:0]        cmd_op_o,
  output logic [7:0]        cmd_data_o,
  output logic              cmd_nack_o,
  input  logic              rsp_valid_i,
  input  logic              rsp_nack_i,
  input  logic [7:0]        rsp_data_i,
  output logic              done_o,
  output logic [1:0]        status_o
);
  phase_e            phase_q, nxt;
  logic              wait_q;
  logic [ALEN_W-1:0] idx_q;
  logic [1:0]        status_q;
  logic [7:0]        rd_q;
  logic              set_st;
  status_e           nxt_st;
  logic              cmd_phase, rsp_take, is_read;

  assign is_read     = (op_i == OP_READ);
  assign req_ready_o = (phase_q == PH_IDLE);
  assign accept_o    = req_valid_i && req_ready_o;
  assign rsp_take    = wait_q && rsp_valid_i;

  always_comb begin
    cmd_phase = 1'b1;
    cmd_op_o  = CMD_WRITE;
    cmd_data_o = 8'd0;
    unique case (phase_q)
      PH_START, PH_TSTART: cmd_op_o = CMD_START;
      PH_TSTOP, PH_STOP:   cmd_op_o = CMD_STOP;
      PH_DEVW:  cmd_data_o = {dev_i, 1'b0};
      PH_DEVR:  cmd_data_o = {dev_i, 1'b1};
      PH_ADDR:  cmd_data_o = addr_byte_i;
      PH_WDATA: cmd_data_o = wr_data_i;
      PH_RDATA: cmd_op_o = CMD_READ;
      default:  cmd_phase = 1'b0;
    endcase
  end

  assign cmd_valid_o = cmd_phase && !wait_q && (phase_q != PH_WDATA || wr_valid_i);
  assign cmd_nack_o  = (phase_q == PH_RDATA) && last_i;
  assign wr_ready_o  = (phase_q == PH_WDATA) && !wait_q && cmd_ready_i;

  always_comb begin
    nxt    = phase_q;
    set_st = 1'b0;
    nxt_st = ST_OK;
    unique case (phase_q)
      PH_START: nxt = (is_read && alen_i == '0) ? PH_DEVR : PH_DEVW;
      PH_DEVW: begin
        if (rsp_nack_i) begin
          nxt = PH_STOP; set_st = 1'b1; nxt_st = ST_NODEV;
        end else if (op_i == OP_PROBE) nxt = PH_STOP;
        else if (alen_i != '0)         nxt = PH_ADDR;
        else                           nxt = zero_i ? PH_STOP : PH_WDATA;
      end
      PH_ADDR: begin
        if (rsp_nack_i) begin
          nxt = PH_STOP; set_st = 1'b1; nxt_st = ST_ADDR;
        end else if (idx_q + ALEN_W'(1) != alen_i) nxt = PH_ADDR;
        else if (is_read) nxt = rep_i ? PH_TSTART : PH_TSTOP;
        else              nxt = zero_i ? PH_STOP : PH_WDATA;
      end
      PH_TSTOP:  nxt = PH_TSTART;
      PH_TSTART: nxt = PH_DEVR;
      PH_DEVR:   nxt = zero_i ? PH_STOP : PH_RDATA;
      PH_WDATA:  nxt = last_i ? PH_STOP : PH_WDATA;
      PH_RDATA:  nxt = PH_RDOUT;
      PH_STOP:   nxt = PH_DONE;
      default:   nxt = phase_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_IDLE;
      wait_q   <= 1'b0;
      idx_q    <= '0;
      status_q <= ST_OK;
      rd_q     <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (req_valid_i) begin
          phase_q  <= PH_START;
          wait_q   <= 1'b0;
          idx_q    <= '0;
          status_q <= ST_OK;
        end
        PH_RDOUT: if (rd_ready_i) phase_q <= last_i ? PH_STOP : PH_RDATA;
        PH_DONE:  phase_q <= PH_IDLE;
        default: begin
          if (!wait_q) begin
            if (cmd_valid_o && cmd_ready_i) wait_q <= 1'b1;
          end else if (rsp_valid_i) begin
            wait_q  <= 1'b0;
            phase_q <= nxt;
            if (set_st) status_q <= nxt_st;
            if (phase_q == PH_ADDR)  idx_q <= idx_q + ALEN_W'(1);
            if (phase_q == PH_RDATA) rd_q  <= rsp_data_i;
          end
        end
      endcase
    end
  end

  assign idx_o      = idx_q;
  assign len_dec_o  = (rsp_take && phase_q == PH_WDATA) || (phase_q == PH_RDOUT && rd_ready_i);
  assign fail_inc_o = rsp_take && phase_q == PH_WDATA && rsp_nack_i;
  assign rd_valid_o = (phase_q == PH_RDOUT);
  assign rd_data_o  = rd_q;
  assign done_o     = (phase_q == PH_DONE);
  assign status_o   = status_q;

  a_r12_cmd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_op_o)
                                    && $stable(cmd_data_o) && $stable(cmd_nack_o));
  a_r6_rd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(rd_data_o));
  a_r13_idle_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> req_ready_o);
  a_r7_status_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> status_o != 2'd3);
  a_r12_one_outstanding: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_q |-> !cmd_valid_o && !req_ready_o);
endmodule

// File: rtl/i2c_mem_seq.sv
module i2c_mem_seq
  import i2c_seq_pkg::*;
#(
  parameter int ADDR_BYTES = 4,
  parameter int LEN_W      = 16,
  localparam int ADDR_W    = 8 * ADDR_BYTES,
  localparam int ALEN_W    = $clog2(ADDR_BYTES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_op_i,
  input  logic [6:0]        req_dev_i,
  input  logic [ADDR_W-1:0] req_mem_addr_i,
  input  logic [ALEN_W-1:0] req_alen_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic              cfg_rep_start_i,
  input  logic              cfg_ovf_en_i,
  input  logic [6:0]        cfg_ovf_mask_i,
  input  logic [7:0]        wr_data_i,
  input  logic              wr_valid_i,
  output logic              wr_ready_o,
  output logic [7:0]        rd_data_o,
  output logic              rd_valid_o,
  input  logic              rd_ready_i,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [1:0]        cmd_op_o,
  output logic [7:0]        cmd_data_o,
  output logic              cmd_nack_o,
  input  logic              rsp_valid_i,
  input  logic              rsp_nack_i,
  input  logic [7:0]        rsp_data_i,
  output logic              done_o,
  output logic [1:0]        status_o,
  output logic [LEN_W-1:0]  fail_cnt_o
);
  logic [1:0]        op_q;
  logic [6:0]        dev_q, mask_q, dev_eff;
  logic [ADDR_W-1:0] addr_q;
  logic [ALEN_W-1:0] alen_q, idx;
  logic              rep_q, ovf_q;
  logic              accept, zero, last, len_dec, fail_inc;
  logic [7:0]        addr_byte;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= '0;
      dev_q  <= '0;
      addr_q <= '0;
      alen_q <= '0;
      rep_q  <= 1'b0;
      ovf_q  <= 1'b0;
      mask_q <= '0;
    end else if (accept) begin
      op_q   <= req_op_i;
      dev_q  <= req_dev_i;
      addr_q <= req_mem_addr_i;
      alen_q <= req_alen_i;
      rep_q  <= cfg_rep_start_i;
      ovf_q  <= cfg_ovf_en_i;
      mask_q <= cfg_ovf_mask_i;
    end
  end

  i2c_seq_addr_fmt #(.ADDR_BYTES(ADDR_BYTES), .ALEN_W(ALEN_W)) u_fmt (
    .dev_i(dev_q), .mem_addr_i(addr_q), .alen_i(alen_q), .idx_i(idx),
    .ovf_en_i(ovf_q), .ovf_mask_i(mask_q),
    .dev_eff_o(dev_eff), .addr_byte_o(addr_byte)
  );

  i2c_seq_len_ctr #(.W(LEN_W)) u_len (
    .clk_i, .rst_ni, .load_i(accept), .len_i(req_len_i), .dec_i(len_dec),
    .zero_o(zero), .last_o(last)
  );

  i2c_seq_fail_ctr #(.W(LEN_W)) u_fail (
    .clk_i, .rst_ni, .clr_i(accept), .bound_i(req_len_i), .inc_i(fail_inc),
    .cnt_o(fail_cnt_o)
  );

  i2c_seq_fsm #(.ALEN_W(ALEN_W)) u_fsm (
    .clk_i, .rst_ni,
    .req_valid_i, .req_ready_o, .accept_o(accept),
    .op_i(op_q), .alen_i(alen_q), .rep_i(rep_q), .dev_i(dev_eff),
    .addr_byte_i(addr_byte), .idx_o(idx),
    .zero_i(zero), .last_i(last), .len_dec_o(len_dec), .fail_inc_o(fail_inc),
    .wr_data_i, .wr_valid_i, .wr_ready_o,
    .rd_data_o, .rd_valid_o, .rd_ready_i,
    .cmd_valid_o, .cmd_ready_i, .cmd_op_o, .cmd_data_o, .cmd_nack_o,
    .rsp_valid_i, .rsp_nack_i, .rsp_data_i,
    .done_o, .status_o
  );
endmodule

// File: tb/i2c_mem_seq_tb.sv
`timescale 1ns/1ps
module i2c_mem_seq_tb;
  localparam int AB = 4, LW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic req_valid = 0, req_ready;
  logic [1:0] req_op = 0;
  logic [6:0] req_dev = 0;
  logic [31:0] req_addr = 0;
  logic [2:0] req_alen = 0;
  logic [LW-1:0] req_len = 0;
  logic rep = 0, oen = 0;
  logic [6:0] omask = 0;
  logic [7:0] wr_data = 0;
  logic wr_valid = 0, wr_ready;
  logic [7:0] rd_data;
  logic rd_valid, rd_ready = 0;
  logic cmd_valid, cmd_ready = 0, cmd_nack;
  logic [1:0] cmd_op;
  logic [7:0] cmd_data;
  logic rsp_valid = 0, rsp_nack = 0;
  logic [7:0] rsp_data = 0;
  logic done;
  logic [1:0] status;
  logic [LW-1:0] fail_cnt;

  i2c_mem_seq #(.ADDR_BYTES(AB), .LEN_W(LW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_op_i(req_op),
    .req_dev_i(req_dev), .req_mem_addr_i(req_addr), .req_alen_i(req_alen),
    .req_len_i(req_len), .cfg_rep_start_i(rep), .cfg_ovf_en_i(oen),
    .cfg_ovf_mask_i(omask), .wr_data_i(wr_data), .wr_valid_i(wr_valid),
    .wr_ready_o(wr_ready), .rd_data_o(rd_data), .rd_valid_o(rd_valid),
    .rd_ready_i(rd_ready), .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready),
    .cmd_op_o(cmd_op), .cmd_data_o(cmd_data), .cmd_nack_o(cmd_nack),
    .rsp_valid_i(rsp_valid), .rsp_nack_i(rsp_nack), .rsp_data_i(rsp_data),
    .done_o(done), .status_o(status), .fail_cnt_o(fail_cnt)
  );

  int n_chk = 0, n_bad = 0;
  string tag = "R13";
  logic [10:0] exp_cmd[$];
  logic [7:0]  exp_rd[$];
  logic [17:0] exp_done[$];
  logic [7:0]  wr_q[$];
  logic [31:0] nack_plan = 0;
  int wcnt = 0, rcnt = 0, done_cnt = 0;
  logic [7:0] rd_seed = 0;

  function automatic logic [10:0] enc(input logic [1:0] op, input logic nk, input logic [7:0] d);
    return {op, nk, d};
  endfunction

  task automatic chk(input bit ok, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  // engine model + command scoreboard
  initial begin
    forever begin
      @(negedge clk);
      rsp_valid = 0;
      if (cmd_valid) begin
        if (exp_cmd.size() == 0) chk(0, "unexpected command", {cmd_op, cmd_nack, cmd_data}, 0);
        else begin
          logic [10:0] e;
          e = exp_cmd.pop_front();
          chk({cmd_op, cmd_nack, cmd_data} == e, "command", {cmd_op, cmd_nack, cmd_data}, e);
        end
        rsp_nack = 0;
        rsp_data = 0;
        if (cmd_op == 2'd2) begin rsp_nack = nack_plan[wcnt]; wcnt++; end
        if (cmd_op == 2'd3) begin rsp_data = rd_seed + 8'(rcnt); rcnt++; end
        cmd_ready = 1;
        @(negedge clk);
        cmd_ready = 0;
        rsp_valid = 1;
      end
    end
  end

  // write-byte source
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (wr_valid && wr_ready) begin
        @(posedge clk);
        #1;
        void'(wr_q.pop_front());
        wr_valid = (wr_q.size() != 0);
        wr_data  = wr_valid ? wr_q[0] : 8'd0;
      end
    end
  end

  // read-byte sink with one stall cycle per byte
  initial begin
    bit stall = 1;
    forever begin
      @(negedge clk);
      if (rd_valid) begin
        if (stall) stall = 0;
        else begin
          if (exp_rd.size() == 0) chk(0, "unexpected read byte", rd_data, 0);
          else begin
            logic [7:0] e;
            e = exp_rd.pop_front();
            chk(rd_data == e, "read byte", rd_data, e);
          end
          rd_ready = 1;
          @(posedge clk);
          #1 rd_ready = 0;
          stall = 1;
        end
      end
    end
  end

  // completion monitor
  initial begin
    forever begin
      @(negedge clk);
      if (done) begin
        if (exp_done.size() == 0) chk(0, "unexpected done", {status, fail_cnt}, 0);
        else begin
          logic [17:0] e;
          e = exp_done.pop_front();
          chk({status, fail_cnt} == e, "status/fail count", {status, fail_cnt}, e);
        end
        done_cnt++;
      end
    end
  end

  task automatic run_txn(input string t, input int op, input logic [6:0] dev,
                         input logic [31:0] addr, input int alen, input int len,
                         input bit rp, input bit oe, input logic [6:0] mk,
                         input logic [31:0] nk, input logic [7:0] seed);
    logic [6:0] devx;
    logic [63:0] wide;
    int widx = 0, fails = 0, target;
    logic [1:0] st = 0;
    bit ended = 0;
    tag = t;
    wide = {32'd0, addr};
    devx = dev | (oe ? (7'(wide >> (8 * alen)) & mk) : 7'd0);
    exp_cmd.push_back(enc(0, 0, 0));
    if (!(op == 1 && alen == 0)) begin
      exp_cmd.push_back(enc(2, 0, {devx, 1'b0}));
      if (nk[widx]) begin st = 1; ended = 1; end
      widx++;
      if (!ended && op != 2) begin
        for (int k = 0; k < alen && !ended; k++) begin
          exp_cmd.push_back(enc(2, 0, 8'(addr >> (8 * (alen - 1 - k)))));
          if (nk[widx]) begin st = 2; ended = 1; end
          widx++;
        end
      end
      if (!ended && op == 0) begin
        for (int i = 0; i < len; i++) begin
          logic [7:0] b;
          b = seed + 8'(7 * i);
          wr_q.push_back(b);
          exp_cmd.push_back(enc(2, 0, b));
          if (nk[widx]) fails++;
          widx++;
        end
        ended = 1;
      end
      if (!ended && op == 1) begin
        if (!rp) exp_cmd.push_back(enc(1, 0, 0));
        exp_cmd.push_back(enc(0, 0, 0));
      end
      if (op == 2) ended = 1;
    end
    if (!ended) begin
      exp_cmd.push_back(enc(2, 0, {devx, 1'b1}));
      for (int i = 0; i < len; i++) begin
        exp_cmd.push_back(enc(3, i == len - 1, 0));
        exp_rd.push_back(seed + 8'(i));
      end
    end
    exp_cmd.push_back(enc(1, 0, 0));
    exp_done.push_back({st, 16'(fails)});

    @(negedge clk);
    nack_plan = nk; wcnt = 0; rcnt = 0; rd_seed = seed;
    wr_valid = (wr_q.size() != 0);
    wr_data  = wr_valid ? wr_q[0] : 8'd0;
    while (!req_ready) @(negedge clk);
    target = done_cnt + 1;
    req_valid = 1; req_op = 2'(op); req_dev = dev; req_addr = addr;
    req_alen = 3'(alen); req_len = 16'(len); rep = rp; oen = oe; omask = mk;
    @(negedge clk);
    req_valid = 0;
    while (done_cnt < target) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(exp_cmd.size() == 0, "commands left over", exp_cmd.size(), 0);
    chk(exp_rd.size() == 0, "read bytes left over", exp_rd.size(), 0);
    exp_cmd.delete(); exp_rd.delete(); wr_q.delete(); wr_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    tag = "R13";
    chk(req_ready == 1, "reset req_ready", req_ready, 1);
    chk(cmd_valid == 0, "reset cmd_valid", cmd_valid, 0);
    chk(rd_valid == 0 && done == 0, "reset rd_valid/done", {rd_valid, done}, 0);

    run_txn("R1 R2 R9 write", 0, 7'h50, 32'h1234, 2, 3, 0, 0, 0, 0, 8'h21);
    run_txn("R9 data nacks", 0, 7'h50, 32'h0abc, 2, 4, 0, 0, 0, 32'b110000, 8'h90);
    run_txn("R5 R6 stop-start read", 1, 7'h51, 32'h7f, 1, 3, 0, 0, 0, 0, 8'hc0);
    run_txn("R5 repeated-start read", 1, 7'h52, 32'hbeef, 2, 2, 1, 0, 0, 0, 8'h30);
    run_txn("R4 no-address read", 1, 7'h33, 32'hffff, 0, 2, 0, 0, 0, 0, 8'h44);
    run_txn("R6 single byte read", 1, 7'h33, 32'h10, 1, 1, 1, 0, 0, 0, 8'h5a);
    run_txn("R3 overflow read", 1, 7'h50, 32'h345, 1, 2, 0, 1, 7'h07, 0, 8'h61);
    run_txn("R3 overflow full-width write", 0, 7'h50, 32'hdeadbeef, 4, 1, 0, 1, 7'h7f, 0, 8'h77);
    run_txn("R3 overflow off", 0, 7'h50, 32'h345, 1, 1, 0, 0, 7'h07, 0, 8'h08);
    run_txn("R7 no device", 0, 7'h2a, 32'h12, 1, 2, 0, 0, 0, 32'b1, 8'h11);
    run_txn("R8 address refused", 1, 7'h2b, 32'h123456, 3, 2, 0, 0, 0, 32'b100, 8'h12);
    run_txn("R10 probe ack", 2, 7'h50, 32'h1, 2, 3, 0, 0, 0, 0, 8'h00);
    run_txn("R10 probe nack", 2, 7'h50, 32'h1, 2, 3, 0, 0, 0, 32'b1, 8'h00);
    run_txn("R11 zero length write", 0, 7'h40, 32'h99, 1, 0, 0, 0, 0, 0, 8'h00);
    run_txn("R11 zero length read", 1, 7'h41, 32'h99, 1, 0, 0, 0, 0, 0, 8'h00);
    run_txn("R12 command codes", 0, 7'h7f, 32'h0, 0, 2, 0, 0, 0, 32'b10, 8'hf0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule